// File: doc/BRIEF.md
# Unsigned Decimal Adder/Subtracter

This block adds or subtracts two unsigned multi-digit decimal numbers held in packed BCD. Each decade sums two digits and an incoming carry in binary, then corrects the binary result back into a decimal digit and a carry that ripples to the next decade. Subtraction adds the nines' complement of the subtrahend. The carry out of the top decade comes back into the bottom decade as an end-around carry. When the difference is negative, a complementer on the output turns it back into a true magnitude.

An operation is accepted on a rising clock edge while the strobe is high. Its result, with an overflow flag in add mode and a negative flag in subtract mode, appears on the registered outputs together with a one-cycle valid pulse. The end-around carry is applied as a second, separate ripple pass, so the logic contains no combinational loop. The digit count is a parameter.

Top module: `bcd_addsub`

## Requirements
- R1: While rst_ni is low and after its release, before any strobe, valid_o, ovf_o and neg_o are 0 and result_o is all zero.
- R2: valid_o is 1 in the cycle after each clock edge at which valid_i is 1, and 0 after an edge at which valid_i is 0.
- R3: In add mode (sub_i = 0), result_o holds (A + B) mod 10^DIGITS as packed BCD.
- R4: In add mode, ovf_o is 1 exactly when A + B >= 10^DIGITS. neg_o is always 0 in add mode.
- R5: In subtract mode (sub_i = 1) with A > B, result_o is A - B, and neg_o and ovf_o are both 0.
- R6: In subtract mode with A < B, result_o is the magnitude B - A, neg_o is 1 and ovf_o is 0.
- R7: In subtract mode with A = B, result_o is all zero and neg_o is 0.
- R8: At a clock edge with valid_i = 0, result_o, ovf_o and neg_o keep their previous values, whatever a_i, b_i and sub_i hold.
- R9: Digit k of every operand and of the result sits at bits [4k+3:4k], with digit 0 the least significant, in 8-4-2-1 weighting. Every result digit is in the range 0 to 9.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Operand strobe |
| sub_i | input | 1 | 1 = compute A - B, 0 = compute A + B |
| a_i | input | 4*DIGITS | Operand A, packed BCD |
| b_i | input | 4*DIGITS | Operand B, packed BCD |
| valid_o | output | 1 | One-cycle pulse: result registers updated |
| result_o | output | 4*DIGITS | Sum, or magnitude of the difference |
| ovf_o | output | 1 | Add-mode carry out of the top decade |
| neg_o | output | 1 | Subtract-mode negative result |

## Verification
Every result, flag and the valid pulse is due exactly one rising edge after the strobed edge. Nothing in the path takes more than that single register stage. The bench changes inputs on falling edges and reads outputs on the next falling edge, which lies half a cycle after the edge that captured them. It streams a new operation every cycle, so each check sees only the operation strobed one edge earlier. For the hold checks, the bench drops the strobe, changes the operands, and reads the outputs on the falling edges after the following rising edges.

// File: rtl/bcd_pkg.sv
package bcd_pkg;
  localparam int unsigned DIGIT_W = 4;
  localparam logic [DIGIT_W-1:0] NINE = 4'd9;
  typedef logic [DIGIT_W-1:0] digit_t;
endpackage

// File: rtl/bcd_decade.sv
module bcd_decade
  import bcd_pkg::*;
(
  input  digit_t a_i,
  input  digit_t b_i,
  input  logic   c_i,
  output digit_t s_o,
  output logic   c_o
);
  logic [DIGIT_W:0] raw;
  logic [DIGIT_W:0] fixed;

  always_comb begin
    raw   = {1'b0, a_i} + {1'b0, b_i} + {{DIGIT_W{1'b0}}, c_i};
    fixed = raw + (DIGIT_W+1)'(6);
    if (raw > (DIGIT_W+1)'(9)) begin
      s_o = fixed[DIGIT_W-1:0];
      c_o = 1'b1;
    end else begin
      s_o = raw[DIGIT_W-1:0];
      c_o = 1'b0;
    end
  end
endmodule

// File: rtl/bcd_ripple.sv
module bcd_ripple
  import bcd_pkg::*;
#(
  parameter int unsigned DIGITS = 4,
  localparam int unsigned W = DIGITS * DIGIT_W
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic         c_i,
  output logic [W-1:0] s_o,
  output logic         c_o
);
  logic [DIGITS:0] carry;
  assign carry[0] = c_i;

  for (genvar k = 0; k < DIGITS; k++) begin : g_dec
    bcd_decade u_dec (
      .a_i (a_i[k*DIGIT_W +: DIGIT_W]),
      .b_i (b_i[k*DIGIT_W +: DIGIT_W]),
      .c_i (carry[k]),
      .s_o (s_o[k*DIGIT_W +: DIGIT_W]),
      .c_o (carry[k+1])
    );
  end

  assign c_o = carry[DIGITS];
endmodule

// File: rtl/bcd_nines.sv
module bcd_nines
  import bcd_pkg::*;
#(
  parameter int unsigned DIGITS = 4,
  localparam int unsigned W = DIGITS * DIGIT_W
) (
  input  logic         en_i,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] d_o
);
  for (genvar k = 0; k < DIGITS; k++) begin : g_dig
    assign d_o[k*DIGIT_W +: DIGIT_W] = en_i ? (NINE - d_i[k*DIGIT_W +: DIGIT_W])
                                            : d_i[k*DIGIT_W +: DIGIT_W];
  end
endmodule

// File: rtl/bcd_addsub.sv
module bcd_addsub
  import bcd_pkg::*;
#(
  parameter int unsigned DIGITS = 4,
  localparam int unsigned W = DIGITS * DIGIT_W
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         valid_i,
  input  logic         sub_i,
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  output logic         valid_o,
  output logic [W-1:0] result_o,
  output logic         ovf_o,
  output logic         neg_o
);
  localparam logic [W-1:0] ALL_NINES = {DIGITS{NINE}};

  logic [W-1:0] b_eff, s_first, s_second, mag;
  logic         c_first, c_second, eac, fix_neg, all_nines;
  logic         ovf_d, neg_d;

  bcd_nines #(.DIGITS(DIGITS)) u_cmp_in (
    .en_i (sub_i), .d_i (b_i), .d_o (b_eff)
  );

  bcd_ripple #(.DIGITS(DIGITS)) u_pass0 (
    .a_i (a_i), .b_i (b_eff), .c_i (1'b0), .s_o (s_first), .c_o (c_first)
  );

  // end-around carry as a second pass, avoids a loop through the chain
  assign eac = sub_i & c_first;

  bcd_ripple #(.DIGITS(DIGITS)) u_pass1 (
    .a_i (s_first), .b_i ('0), .c_i (eac), .s_o (s_second), .c_o (c_second)
  );

  assign fix_neg = sub_i & ~c_first;

  bcd_nines #(.DIGITS(DIGITS)) u_cmp_out (
    .en_i (fix_neg), .d_i (s_second), .d_o (mag)
  );

  // all-nines nines'-complement sum is a negative zero
  assign all_nines = (s_first == ALL_NINES);
  assign ovf_d     = ~sub_i & (c_first | c_second);
  assign neg_d     = fix_neg & ~all_nines;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o  <= 1'b0;
      result_o <= '0;
      ovf_o    <= 1'b0;
      neg_o    <= 1'b0;
    end else begin
      valid_o <= valid_i;
      if (valid_i) begin
        result_o <= mag;
        ovf_o    <= ovf_d;
        neg_o    <= neg_d;
      end
    end
  end
endmodule

// File: rtl/bcd_addsub_chk.sv
module bcd_addsub_chk
  import bcd_pkg::*;
#(
  parameter int unsigned DIGITS = 4,
  localparam int unsigned W = DIGITS * DIGIT_W
) (
  input logic         clk_i,
  input logic         rst_ni,
  input logic         valid_i,
  input logic         sub_i,
  input logic [W-1:0] a_i,
  input logic [W-1:0] b_i,
  input logic         valid_o,
  input logic [W-1:0] result_o,
  input logic         ovf_o,
  input logic         neg_o
);
  logic digits_ok;
  always_comb begin
    digits_ok = 1'b1;
    for (int k = 0; k < DIGITS; k++)
      if (result_o[k*DIGIT_W +: DIGIT_W] > NINE) digits_ok = 1'b0;
  end

  assert_pulse_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> valid_o);
  assert_idle_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> !valid_o);
  assert_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> ($stable(result_o) && $stable(ovf_o) && $stable(neg_o)));
  assert_no_neg_in_add_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && !sub_i) |=> !neg_o);
  assert_no_ovf_in_sub_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && sub_i) |=> !ovf_o);
  assert_equal_zero_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && sub_i && a_i == b_i) |=> (result_o == '0 && !neg_o));
  assert_neg_nonzero_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    neg_o |-> result_o != '0);
  assert_digit_range_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    digits_ok);
endmodule

bind bcd_addsub bcd_addsub_chk #(.DIGITS(DIGITS)) u_chk (
  .clk_i (clk_i), .rst_ni (rst_ni), .valid_i (valid_i), .sub_i (sub_i),
  .a_i (a_i), .b_i (b_i), .valid_o (valid_o), .result_o (result_o),
  .ovf_o (ovf_o), .neg_o (neg_o)
);

// File: tb/tb_bcd_addsub.sv
`timescale 1ns/1ps
module tb_bcd_addsub;
  localparam int DIGITS = 2;
  localparam int W = 4 * DIGITS;
  localparam int MODV = 100;

  logic         clk_i = 1'b0;
  logic         rst_ni = 1'b0;
  logic         valid_i = 1'b0;
  logic         sub_i = 1'b0;
  logic [W-1:0] a_i = '0;
  logic [W-1:0] b_i = '0;
  logic         valid_o, ovf_o, neg_o;
  logic [W-1:0] result_o;

  int checks = 0;
  int failures = 0;

  always #2.5 clk_i = ~clk_i;

  bcd_addsub #(.DIGITS(DIGITS)) dut (
    .clk_i (clk_i), .rst_ni (rst_ni), .valid_i (valid_i), .sub_i (sub_i),
    .a_i (a_i), .b_i (b_i), .valid_o (valid_o), .result_o (result_o),
    .ovf_o (ovf_o), .neg_o (neg_o)
  );

  function automatic logic [W-1:0] to_bcd(int v);
    logic [W-1:0] r = '0;
    for (int k = 0; k < DIGITS; k++) begin
      r[4*k +: 4] = 4'(v % 10);
      v = v / 10;
    end
    return r;
  endfunction

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic run_op(int a, int b, bit sub);
    int exp_r;
    bit exp_o, exp_n;
    string tag;
    valid_i = 1'b1;
    sub_i   = sub;
    a_i     = to_bcd(a);
    b_i     = to_bcd(b);
    if (!sub) begin
      exp_r = (a + b) % MODV; exp_o = (a + b) >= MODV; exp_n = 1'b0; tag = "R3/R4 add";
    end else if (a > b) begin
      exp_r = a - b; exp_o = 1'b0; exp_n = 1'b0; tag = "R5 sub pos";
    end else if (a < b) begin
      exp_r = b - a; exp_o = 1'b0; exp_n = 1'b1; tag = "R6 sub neg";
    end else begin
      exp_r = 0; exp_o = 1'b0; exp_n = 1'b0; tag = "R7 sub equal";
    end
    @(negedge clk_i);
    chk({tag, " result R9"}, int'(result_o), int'(to_bcd(exp_r)));
    chk({tag, " flags"}, int'({valid_o, ovf_o, neg_o}), int'({1'b1, exp_o, exp_n}));
  endtask

  initial begin
    #(5.0 * 200000);
    failures++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [W-1:0] held;
    repeat (3) @(negedge clk_i);
    chk("R1 reset in", int'({valid_o, ovf_o, neg_o, result_o}), 0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk("R1 reset out", int'({valid_o, ovf_o, neg_o, result_o}), 0);

    for (int s = 0; s < 2; s++)
      for (int a = 0; a < MODV; a++)
        for (int b = 0; b < MODV; b++)
          run_op(a, b, bit'(s));

    // R2 single pulse, then R8 hold under changing inputs
    run_op(57, 83, 1'b0);
    held = result_o;
    valid_i = 1'b0;
    sub_i = 1'b1;
    a_i = to_bcd(12);
    b_i = to_bcd(99);
    @(negedge clk_i);
    chk("R2 pulse ends", int'(valid_o), 0);
    chk("R8 hold result", int'(result_o), int'(held));
    chk("R8 hold flags", int'({ovf_o, neg_o}), int'(2'b10));
    a_i = to_bcd(0);
    sub_i = 1'b0;
    @(negedge clk_i);
    chk("R8 hold again", int'({valid_o, ovf_o, neg_o, result_o}), int'({3'b010, held}));

    run_op(3, 98, 1'b1);
    run_op(0, 0, 1'b1);
    run_op(99, 99, 1'b0);
    valid_i = 1'b0;
    @(negedge clk_i);
    chk("R2 idle", int'(valid_o), 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule